// File: doc/BRIEF.md
# Conditional ALU with Flag Generation

This block is the data-processing stage of a 32-bit integer datapath. Every cycle it receives a 4-bit condition code, a 4-bit operation code, a set-flags request, a first operand, a second operand that has already passed through a shifter, and that shifter's carry-out. It first tests the condition code against the stored negative, zero, carry and overflow flags. It then computes the result of the selected operation. It raises a result write-enable only for operations that produce a register result and only when the condition passed.

The flag store is a 4-bit register. It is loaded on a rising clock edge only when the condition passed and set-flags is high. Logical operations take their carry from the shifter and keep the stored overflow. Arithmetic operations derive carry and overflow from the operand and result sign bits. The compare and test operations update the flags and never write a result. A separate "condition passed" output lets a surrounding pipeline, or a bench, see which instructions were suppressed.

Top module: `cond_alu`

## Requirements
- R1: `cond_pass_o` follows the condition code against the stored flags, using these encodings:
  - 0: Z
  - 1: !Z
  - 2: C
  - 3: !C
  - 4: N
  - 5: !N
  - 6: V
  - 7: !V
  - 8: C&!Z
  - 9: !C|Z
  - 10: N==V
  - 11: N!=V
  - 12: !Z&(N==V)
  - 13: Z|(N!=V)
  - 14: always
- R2: Condition code 15 never passes. When the condition fails, `wr_en_o` is low and the flags stay unchanged across the next edge.
- R3: `result_o` is computed from the operation code as follows:
  - 0x0: A&B
  - 0x1: A^B
  - 0x2: A-B
  - 0x3: B-A
  - 0x4: A+B
  - 0xC: A|B
  - 0xD: B
  - 0xE: A&~B
  - 0xF: ~B
- R4: Operation codes 0x8 (AND test), 0x9 (XOR test), 0xA (subtract compare) and 0xB (add compare) never raise `wr_en_o`. Every other code raises it exactly when the condition passes.
- R5: Three operations use the stored carry C:
  - 0x5 computes A+B+C.
  - 0x6 computes A-B-(1-C).
  - 0x7 computes B-A-(1-C).
- R6: The logical operations are 0x0, 0x1, 0x8, 0x9, 0xC, 0xD, 0xE and 0xF. When they update the flags, C takes `shift_carry_i` and V keeps its stored value.
- R7: The add-type operations are 0x4, 0x5 and 0xB. For these, C is bit 31 of (a&b)|(a&~r)|(b&~r) and V is bit 31 of (a&b&~r)|(~a&~b&r).
- R8: The subtract-type operations are 0x2, 0x6 and 0xA, with a=A and b=B; 0x3 and 0x7 use a=B and b=A. For all of them, C is bit 31 of (a&~b)|(a&~r)|(~b&~r) and V is bit 31 of (a&~b&~r)|(~a&b&r).
- R9: On a flag update, N is bit 31 of the result and Z is set exactly when the 32-bit result is zero.
- R10: With `set_flags_i` low, the flags do not change.
- R11: Synchronous active-high reset clears the flags. `flags_o` packs the flags as N in bit 3, Z in bit 2, C in bit 1 and V in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_i | input | 4 | Condition code |
| op_i | input | 4 | Operation code |
| set_flags_i | input | 1 | Request flag update |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Shifted second operand |
| shift_carry_i | input | 1 | Shifter carry-out |
| result_o | output | 32 | Operation result |
| wr_en_o | output | 1 | Result write-enable |
| cond_pass_o | output | 1 | Condition passed |
| flags_o | output | 4 | Stored N,Z,C,V |

## Verification
A wrong flag computation or a wrongly gated flag load shows up on `flags_o` one edge after the offending instruction. It also shows up in the same cycle on `cond_pass_o` and `result_o` of every later instruction whose condition or carry-in reads the corrupted flag. The bench therefore checks the combinational outputs in each cycle and the flag register after each edge, against a model that carries its own flag copy. The sweep covers every condition code and every operation code, both set-flags values and alternating shifter carries, starting from flags preset by compares of sign-boundary operands.

// File: rtl/cond_alu_pkg.sv
package cond_alu_pkg;

    typedef enum logic [3:0] {
        OPC_AND = 4'h0, OPC_EOR = 4'h1, OPC_SUB = 4'h2, OPC_RSB = 4'h3,
        OPC_ADD = 4'h4, OPC_ADC = 4'h5, OPC_SBC = 4'h6, OPC_RSC = 4'h7,
        OPC_TST = 4'h8, OPC_TEQ = 4'h9, OPC_CMP = 4'hA, OPC_CMN = 4'hB,
        OPC_ORR = 4'hC, OPC_MOV = 4'hD, OPC_BIC = 4'hE, OPC_MVN = 4'hF
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    // Condition evaluation against stored flags
    function automatic logic cond_holds(input logic [3:0] code, input nzcv_t f);
        logic r;
        case (code)
            4'd0:  r = f.z;
            4'd1:  r = !f.z;
            4'd2:  r = f.c;
            4'd3:  r = !f.c;
            4'd4:  r = f.n;
            4'd5:  r = !f.n;
            4'd6:  r = f.v;
            4'd7:  r = !f.v;
            4'd8:  r = f.c && !f.z;
            4'd9:  r = !f.c || f.z;
            4'd10: r = (f.n == f.v);
            4'd11: r = (f.n != f.v);
            4'd12: r = !f.z && (f.n == f.v);
            4'd13: r = f.z || (f.n != f.v);
            4'd14: r = 1'b1;
            default: r = 1'b0;
        endcase
        return r;
    endfunction

    function automatic logic op_is_compare(input alu_op_e op);
        return (op == OPC_TST) || (op == OPC_TEQ) || (op == OPC_CMP) || (op == OPC_CMN);
    endfunction

    function automatic logic op_is_logical(input alu_op_e op);
        return (op == OPC_AND) || (op == OPC_EOR) || (op == OPC_TST) || (op == OPC_TEQ) ||
               (op == OPC_ORR) || (op == OPC_MOV) || (op == OPC_BIC) || (op == OPC_MVN);
    endfunction

endpackage

// File: rtl/cc_eval.sv
module cc_eval
    import cond_alu_pkg::*;
(
    input  logic [3:0] cond_i,
    input  nzcv_t      flags_i,
    output logic       pass_o
);
    always_comb pass_o = cond_holds(cond_i, flags_i);
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
    import cond_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  alu_op_e          op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             shc_i,
    input  nzcv_t            cur_i,
    output logic [WIDTH-1:0] res_o,
    output nzcv_t            nxt_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] x, y, arith, logic_r;
    logic             cin, is_sub, is_logic;
    logic [WIDTH-1:0] c_vec, v_vec;

    // Operand routing for the adder
    always_comb begin
        x = a_i; y = b_i; cin = 1'b0; is_sub = 1'b0;
        case (op_i)
            OPC_SUB, OPC_CMP: begin is_sub = 1'b1; cin = 1'b1; end
            OPC_RSB: begin x = b_i; y = a_i; is_sub = 1'b1; cin = 1'b1; end
            OPC_ADC: cin = cur_i.c;
            OPC_SBC: begin is_sub = 1'b1; cin = cur_i.c; end
            OPC_RSC: begin x = b_i; y = a_i; is_sub = 1'b1; cin = cur_i.c; end
            default: ;
        endcase
        arith = is_sub ? (x + ~y + WIDTH'(cin)) : (x + y + WIDTH'(cin));
    end

    always_comb begin
        case (op_i)
            OPC_AND, OPC_TST: logic_r = a_i & b_i;
            OPC_EOR, OPC_TEQ: logic_r = a_i ^ b_i;
            OPC_ORR:          logic_r = a_i | b_i;
            OPC_MOV:          logic_r = b_i;
            OPC_BIC:          logic_r = a_i & ~b_i;
            default:          logic_r = ~b_i;
        endcase
        is_logic = op_is_logical(op_i);
        res_o    = is_logic ? logic_r : arith;
    end

    // Carry and overflow from sign bits
    always_comb begin
        if (is_sub) begin
            c_vec = (x & ~y) | (x & ~arith) | (~y & ~arith);
            v_vec = (x & ~y & ~arith) | (~x & y & arith);
        end else begin
            c_vec = (x & y) | (x & ~arith) | (y & ~arith);
            v_vec = (x & y & ~arith) | (~x & ~y & arith);
        end
        nxt_o.n = res_o[MSB];
        nxt_o.z = (res_o == '0);
        nxt_o.c = is_logic ? shc_i   : c_vec[MSB];
        nxt_o.v = is_logic ? cur_i.v : v_vec[MSB];
    end
endmodule

// File: rtl/nzcv_store.sv
module nzcv_store
    import cond_alu_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load_i,
    input  nzcv_t d_i,
    output nzcv_t q_o
);
    always_ff @(posedge clk) begin
        if (rst)         q_o <= '0;
        else if (load_i) q_o <= d_i;
    end

    // R10
    no_load_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(q_o));
endmodule

// File: rtl/cond_alu.sv
module cond_alu
    import cond_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       cond_i,
    input  logic [3:0]       op_i,
    input  logic             set_flags_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             shift_carry_i,
    output logic [WIDTH-1:0] result_o,
    output logic             wr_en_o,
    output logic             cond_pass_o,
    output logic [3:0]       flags_o
);
    alu_op_e op;
    nzcv_t   cur, nxt;
    logic    pass, load;

    assign op = alu_op_e'(op_i);

    cc_eval u_cc (.cond_i(cond_i), .flags_i(cur), .pass_o(pass));

    alu_datapath #(.WIDTH(WIDTH)) u_dp (
        .op_i(op), .a_i(a_i), .b_i(b_i), .shc_i(shift_carry_i),
        .cur_i(cur), .res_o(result_o), .nxt_o(nxt)
    );

    assign load = pass && set_flags_i;

    nzcv_store u_fl (.clk(clk), .rst(rst), .load_i(load), .d_i(nxt), .q_o(cur));

    assign cond_pass_o = pass;
    assign wr_en_o     = pass && !op_is_compare(op);
    assign flags_o     = cur;

    // R2
    never_cond_chk: assert property (@(posedge clk) disable iff (rst)
        (cond_i == 4'hF) |-> !cond_pass_o);

    // R2
    fail_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cond_pass_o |=> $stable(flags_o));

    // R4
    cmp_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i[3:2] == 2'b10) |-> !wr_en_o);

    // R6
    logic_v_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (cond_pass_o && set_flags_i && op_is_logical(op)) |=> (flags_o[0] == $past(flags_o[0])));

    // R9
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (cond_pass_o && set_flags_i) |=> (flags_o[2] == ($past(result_o) == '0)));
endmodule

// File: tb/cond_alu_bench.sv
module cond_alu_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  cond, op;
    logic        sf, shc;
    logic [31:0] a, b;
    logic [31:0] result;
    logic        wr_en, pass;
    logic [3:0]  flags;

    int total = 0;
    int bad   = 0;
    logic [3:0] mf = 4'h0;   // model flags N,Z,C,V

    always #4 clk = ~clk;

    cond_alu u_cond_alu (
        .clk(clk), .rst(rst), .cond_i(cond), .op_i(op), .set_flags_i(sf),
        .a_i(a), .b_i(b), .shift_carry_i(shc), .result_o(result),
        .wr_en_o(wr_en), .cond_pass_o(pass), .flags_o(flags)
    );

    function automatic logic m_cond(input int code, input logic [3:0] f);
        logic n, z, c, v;
        n = f[3]; z = f[2]; c = f[1]; v = f[0];
        case (code)
            0: return z;            1: return ~z;
            2: return c;            3: return ~c;
            4: return n;            5: return ~n;
            6: return v;            7: return ~v;
            8: return c & ~z;       9: return ~c | z;
            10: return ~(n ^ v);    11: return n ^ v;
            12: return ~z & ~(n ^ v);
            13: return z | (n ^ v);
            14: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int c_in, input int o_in, input logic s_in,
                        input logic [31:0] a_in, input logic [31:0] b_in, input logic k_in);
        logic        ep, ew, logical, is_sub, cin;
        logic [31:0] er, x, y;
        logic [3:0]  nf;
        longint      tmp;
        @(negedge clk);
        cond = 4'(c_in); op = 4'(o_in); sf = s_in; a = a_in; b = b_in; shc = k_in;
        #1;
        ep = m_cond(c_in, mf);
        logical = (o_in inside {0, 1, 8, 9, 12, 13, 14, 15});
        ew = ep && !(o_in inside {8, 9, 10, 11});
        cin = mf[1];
        is_sub = (o_in inside {2, 3, 6, 7, 10});
        x = (o_in == 3 || o_in == 7) ? b_in : a_in;
        y = (o_in == 3 || o_in == 7) ? a_in : b_in;
        case (o_in)
            0, 8:  er = a_in & b_in;
            1, 9:  er = a_in ^ b_in;
            12:    er = a_in | b_in;
            13:    er = b_in;
            14:    er = a_in & ~b_in;
            15:    er = ~b_in;
            4, 11: begin tmp = longint'(x) + longint'(y); er = tmp[31:0]; end
            5:     begin tmp = longint'(x) + longint'(y) + longint'(cin); er = tmp[31:0]; end
            6, 7:  begin tmp = longint'(x) - longint'(y) - longint'(!cin); er = tmp[31:0]; end
            default: begin tmp = longint'(x) - longint'(y); er = tmp[31:0]; end
        endcase
        nf[3] = er[31];
        nf[2] = (er == 32'd0);
        if (logical) begin
            nf[1] = k_in; nf[0] = mf[0];
        end else if (is_sub) begin
            nf[1] = ((x[31] & ~y[31]) | (x[31] & ~er[31]) | (~y[31] & ~er[31]));
            nf[0] = ((x[31] & ~y[31] & ~er[31]) | (~x[31] & y[31] & er[31]));
        end else begin
            nf[1] = ((x[31] & y[31]) | (x[31] & ~er[31]) | (y[31] & ~er[31]));
            nf[0] = ((x[31] & y[31] & ~er[31]) | (~x[31] & ~y[31] & er[31]));
        end
        chk((c_in == 15) ? "R2 pass" : "R1 pass", longint'(pass), longint'(ep));
        chk((c_in == 15) ? "R2 wr_en" : "R4 wr_en", longint'(wr_en), longint'(ew));
        chk((o_in inside {5, 6, 7}) ? "R5 result" : "R3 result", longint'(result), longint'(er));
        @(posedge clk);
        #1;
        if (ep && s_in) begin
            chk("R9 NZ", longint'(flags[3:2]), longint'(nf[3:2]));
            chk(logical ? "R6 CV" : (is_sub ? "R8 CV" : "R7 CV"),
                longint'(flags[1:0]), longint'(nf[1:0]));
            mf = nf;
        end else begin
            chk(!ep ? "R2 hold" : "R10 hold", longint'(flags), longint'(mf));
        end
    endtask

    logic [31:0] pa [9] = '{32'h0, 32'h1, 32'h5, 32'h3, 32'h7FFFFFFF,
                            32'h80000000, 32'hFFFFFFFF, 32'h80000000, 32'h12345678};
    logic [31:0] pb [9] = '{32'h0, 32'h1, 32'h3, 32'h5, 32'h1,
                            32'h1, 32'h1, 32'h80000000, 32'h0F0F0F0F};

    initial begin
        cond = 4'hE; op = 4'hD; sf = 1'b0; a = '0; b = '0; shc = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R11 reset flags", longint'(flags), 0);
        for (int p = 0; p < 9; p++) begin
            for (int pre = 0; pre < 2; pre++) begin
                step(14, (pre == 0) ? 10 : 11, 1'b1, pa[p], pb[p], 1'b0);
                for (int c = 0; c < 16; c++) begin
                    for (int o = 0; o < 16; o++) begin
                        for (int s = 0; s < 2; s++) begin
                            int q;
                            q = (p + c + o) % 9;
                            step(c, o, s[0], pa[q], pb[(q + s) % 9], o[0] ^ c[0]);
                        end
                    end
                end
            end
        end
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        chk("R11 reset clears", longint'(flags), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule